// File: doc/BRIEF.md
# JTAG TAP State Navigator

This block steers the test access port controller of an attached JTAG target from one controller state to another. A request names a source state, a destination state and a start strobe. The block works out the TMS bit sequence for the shortest route. It then plays that sequence out one bit per TCK period and raises a one-cycle done pulse when the sequence ends. The block keeps a register of where it believes the target's controller sits. It updates that register on every rising TCK it issues, and it exposes the value so the surrounding logic can use it as a source.

Any request whose destination is Test-Logic-Reset takes a fixed run of TMS-high clocks, which reaches that state from anywhere. After its own reset the block makes such a run on its own. TCK is made by dividing the system clock, with separate programmable lengths for the low and the high phase. TDI stays high for the whole time. Shifting data and capturing TDO are handled elsewhere.

Top module: `tap_walker`

## Requirements
- R1: While reset is asserted, TCK is 0, TDI is 1 and TMS is 1. After reset is released, the block issues 9 TCK cycles with TMS=1 and then reports state 0, without any request.
- R2: State codes are 4-bit: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. After a request completes, `cur_state` equals the resolved destination.
- R3: For any destination other than 0, the block issues the shortest TMS route, one bit per rising TCK. Read as a pattern with the first bit in bit 0, some examples are: 1→4 gives 0x01 in 3 bits, 1→11 gives 0x03 in 4, 0→1 gives 0x00 in 1, 4→1 gives 0x03 in 3, 11→15 gives 0x03 in 2, and 6→11 gives 0x0F in 6.
- R4: A destination that resolves to 0 always produces exactly 9 TCK cycles with TMS=1, whatever the source.
- R5: When the source code equals the destination code, no TCK cycle is issued, done pulses, and the state is unchanged.
- R6: Code 16 in either the source or the destination field stands for the current `cur_state`. It is resolved before the route is chosen.
- R7: If the resolved source equals the resolved destination while the codes differ, the result depends on the state. Run-Test/Idle, Pause-DR and Pause-IR get one TCK with TMS=0. Every other state gets no cycle.
- R8: A source or destination code above 16 raises `err` for one cycle, issues no TCK, gives no done pulse, and leaves `cur_state` unchanged.
- R9: TMS is stable while TCK is high, and changes only at the falling edge or during the low phase. TDI is 1 at every rising TCK.
- R10: Each TCK low phase lasts `lo_clks` system clocks and each high phase lasts `hi_clks`, with the value 0 treated as 1. TCK is low whenever the block is idle.
- R11: `start` is ignored while `busy` is high. `done` is a single-cycle pulse at the end of every accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| src_code | input | 5 | Source state code (0–15, 16 = current) |
| dst_code | input | 5 | Destination state code (0–15, 16 = current) |
| lo_clks | input | HALF_W | TCK low-phase length in system clocks |
| hi_clks | input | HALF_W | TCK high-phase length in system clocks |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data in, held high |
| busy | output | 1 | Sequence in progress (including the post-reset run) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected code |
| cur_state | output | 4 | Tracked controller state |

## Verification
The hardest case to reach from the ports is the resolved self-transition. The source must be code 16 while the tracked state already equals the destination, so the block first has to be driven into Pause-DR, Shift-IR or Run-Test/Idle by earlier requests. The bench chains requests to do this, mixing code 16 in the source field and in the destination field. It then checks that the pause and idle states get one TMS-low clock and the shift state gets none. A second hard case is a start pulse that arrives while a sequence is running. The bench raises one in the middle of a four-bit route and checks that the bit count and the final state show no trace of it.

// File: rtl/tap_walker_pkg.sv
package tap_walker_pkg;

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CUR_CODE = 5'd16;

  typedef enum logic [3:0] {
    S_TLR   = 4'd0,
    S_RTI   = 4'd1,
    S_SELDR = 4'd2,
    S_CAPDR = 4'd3,
    S_SHDR  = 4'd4,
    S_EX1DR = 4'd5,
    S_PSDR  = 4'd6,
    S_EX2DR = 4'd7,
    S_UPDR  = 4'd8,
    S_SELIR = 4'd9,
    S_CAPIR = 4'd10,
    S_SHIR  = 4'd11,
    S_EX1IR = 4'd12,
    S_PSIR  = 4'd13,
    S_EX2IR = 4'd14,
    S_UPIR  = 4'd15
  } tap_st_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  // Controller transition on one rising TCK with the given TMS level.
  function automatic tap_st_t tap_next(tap_st_t s, logic m);
    tap_st_t n;
    case (s)
      S_TLR:   n = m ? S_TLR   : S_RTI;
      S_RTI:   n = m ? S_SELDR : S_RTI;
      S_SELDR: n = m ? S_SELIR : S_CAPDR;
      S_CAPDR: n = m ? S_EX1DR : S_SHDR;
      S_SHDR:  n = m ? S_EX1DR : S_SHDR;
      S_EX1DR: n = m ? S_UPDR  : S_PSDR;
      S_PSDR:  n = m ? S_EX2DR : S_PSDR;
      S_EX2DR: n = m ? S_UPDR  : S_SHDR;
      S_UPDR:  n = m ? S_SELDR : S_RTI;
      S_SELIR: n = m ? S_TLR   : S_CAPIR;
      S_CAPIR: n = m ? S_EX1IR : S_SHIR;
      S_SHIR:  n = m ? S_EX1IR : S_SHIR;
      S_EX1IR: n = m ? S_UPIR  : S_PSIR;
      S_PSIR:  n = m ? S_EX2IR : S_PSIR;
      S_EX2IR: n = m ? S_UPIR  : S_SHIR;
      default: n = m ? S_SELDR : S_RTI;
    endcase
    return n;
  endfunction

  // First TMS bit on the shortest route from s towards t (s != t).
  // Column states are folded to a local index: Sel=0 Cap=1 Sh=2 Ex1=3
  // Pause=4 Ex2=5 Upd=6, identical for the DR and IR columns.
  function automatic logic tap_hop(tap_st_t s, tap_st_t t);
    logic [3:0] sv, tv, sl, tl;
    logic       s_ir, t_ir, t_col, m;
    sv    = s;
    tv    = t;
    s_ir  = (sv >= 4'd9);
    t_ir  = (tv >= 4'd9);
    sl    = s_ir ? (sv - 4'd9) : (sv - 4'd2);
    tl    = t_ir ? (tv - 4'd9) : (tv - 4'd2);
    t_col = (tv >= 4'd2) && (s_ir == t_ir);
    case (s)
      S_TLR:   m = (t == S_TLR);
      S_RTI:   m = (t != S_RTI);
      default: begin
        case (sl)
          4'd0:    m = !t_col;
          4'd1:    m = !(t_col && (tl == 4'd2));
          4'd2:    m = 1'b1;
          4'd3:    m = !(t_col && ((tl == 4'd2) || (tl == 4'd4) || (tl == 4'd5)));
          4'd4:    m = 1'b1;
          4'd5:    m = !(t_col && ((tl == 4'd2) || (tl == 4'd3) || (tl == 4'd4)));
          default: m = (t != S_RTI);
        endcase
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tap_phase_timer.sv
module tap_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic         expire
);

  logic [W-1:0] cnt_q, cnt_d, lim_eff;

  always_comb begin
    lim_eff = (lim == '0) ? W'(1) : lim;
    expire  = !clr && (cnt_q == lim_eff - W'(1));
    if (clr || expire) cnt_d = '0;
    else               cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tap_route.sv
module tap_route
  import tap_walker_pkg::*;
(
  input  tap_st_t cur,
  input  tap_st_t tgt,
  input  logic    tms_in,
  output logic    hop_tms,
  output tap_st_t nxt
);

  always_comb begin
    hop_tms = tap_hop(cur, tgt);
    nxt     = tap_next(cur, tms_in);
  end

endmodule

// File: rtl/tap_walker.sv
module tap_walker
  import tap_walker_pkg::*;
#(
  parameter int HALF_W     = 8,
  parameter int RESET_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4:0]        src_code,
  input  logic [4:0]        dst_code,
  input  logic [HALF_W-1:0] lo_clks,
  input  logic [HALF_W-1:0] hi_clks,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [3:0]        cur_state
);

  localparam int LEFT_W = $clog2(RESET_BITS + 1);

  phase_t            ph_q, ph_d;
  logic              tck_q, tck_d, tms_q, tms_d;
  tap_st_t           walk_q, walk_d, tgt_q, tgt_d;
  logic              fixed_q, fixed_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              boot_q, boot_d, done_q, done_d, err_q, err_d;

  logic [4:0]        req_src, req_dst;
  logic              req_go, req_bad;
  tap_st_t           src_r, dst_r, rt_cur, rt_tgt, rt_nxt;
  logic              rt_hop, tmr_exp, fin;
  logic [HALF_W-1:0] tmr_lim;

  // Request decode: the post-reset run is an implicit "current -> reset".
  always_comb begin
    req_src = boot_q ? CUR_CODE : src_code;
    req_dst = boot_q ? 5'd0     : dst_code;
    req_go  = (ph_q == PH_IDLE) && (boot_q || start);
    req_bad = (req_src > CUR_CODE) || (req_dst > CUR_CODE);
    src_r   = (req_src == CUR_CODE) ? walk_q : tap_st_t'(req_src[3:0]);
    dst_r   = (req_dst == CUR_CODE) ? walk_q : tap_st_t'(req_dst[3:0]);
    rt_cur  = (ph_q == PH_IDLE) ? src_r : walk_q;
    rt_tgt  = (ph_q == PH_IDLE) ? dst_r : tgt_q;
    tmr_lim = (ph_q == PH_HIGH) ? hi_clks : lo_clks;
  end

  tap_route u_route (
    .cur     (rt_cur),
    .tgt     (rt_tgt),
    .tms_in  (tms_q),
    .hop_tms (rt_hop),
    .nxt     (rt_nxt)
  );

  tap_phase_timer #(.W(HALF_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ph_q == PH_IDLE),
    .lim    (tmr_lim),
    .expire (tmr_exp)
  );

  always_comb begin
    ph_d    = ph_q;
    tck_d   = tck_q;
    tms_d   = tms_q;
    walk_d  = walk_q;
    tgt_d   = tgt_q;
    fixed_d = fixed_q;
    left_d  = left_q;
    boot_d  = boot_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    fin     = fixed_q ? (left_q == '0) : (walk_q == tgt_q);
    case (ph_q)
      PH_IDLE: begin
        if (req_go) begin
          boot_d = 1'b0;
          if (req_bad) begin
            err_d = 1'b1;
          end else if (req_src == req_dst) begin
            done_d = 1'b1;
          end else if (dst_r == S_TLR) begin
            fixed_d = 1'b1;
            left_d  = LEFT_W'(RESET_BITS);
            tms_d   = 1'b1;
            walk_d  = src_r;
            ph_d    = PH_LOW;
          end else if (src_r == dst_r) begin
            if ((dst_r == S_RTI) || (dst_r == S_PSDR) || (dst_r == S_PSIR)) begin
              fixed_d = 1'b1;
              left_d  = LEFT_W'(1);
              tms_d   = 1'b0;
              ph_d    = PH_LOW;
            end else begin
              done_d = 1'b1;
            end
          end else begin
            fixed_d = 1'b0;
            walk_d  = src_r;
            tgt_d   = dst_r;
            tms_d   = rt_hop;
            ph_d    = PH_LOW;
          end
        end
      end
      PH_LOW: begin
        if (tmr_exp) begin
          tck_d  = 1'b1;
          walk_d = rt_nxt;
          if (fixed_q) left_d = left_q - LEFT_W'(1);
          ph_d   = PH_HIGH;
        end
      end
      PH_HIGH: begin
        if (tmr_exp) begin
          tck_d = 1'b0;
          if (fin) begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end else begin
            ph_d = PH_LOW;
            if (!fixed_q) tms_d = rt_hop;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      tck_q   <= 1'b0;
      tms_q   <= 1'b1;
      walk_q  <= S_TLR;
      tgt_q   <= S_TLR;
      fixed_q <= 1'b1;
      left_q  <= '0;
      boot_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      tck_q   <= tck_d;
      tms_q   <= tms_d;
      walk_q  <= walk_d;
      tgt_q   <= tgt_d;
      fixed_q <= fixed_d;
      left_q  <= left_d;
      boot_q  <= boot_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign tck       = tck_q;
  assign tms       = tms_q;
  assign tdi       = 1'b1;
  assign busy      = boot_q || (ph_q != PH_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign cur_state = walk_q;

endmodule

// File: rtl/tap_walker_chk.sv
module tap_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tck,
  input logic       tms,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [3:0] cur_state
);

  p_tms_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> $stable(tms));

  p_idle_tck_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done && !tck));

  p_err_state_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(cur_state));

endmodule

bind tap_walker tap_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tck       (tck),
  .tms       (tms),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .cur_state (cur_state)
);

// File: tb/test_tap_walker.sv
module test_tap_walker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] src_code = 5'd0, dst_code = 5'd0;
  logic [7:0] lo_clks = 8'd2, hi_clks = 8'd1;
  logic       tck, tms, tdi, busy, done, err;
  logic [3:0] cur_state;

  int n_chk = 0, n_bad = 0;

  tap_walker i_tap_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .src_code(src_code),
    .dst_code(dst_code), .lo_clks(lo_clks), .hi_clks(hi_clks),
    .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
    .err(err), .cur_state(cur_state)
  );

  always #5 clk = ~clk;

  // Monitor, sampled on the falling system clock edge.
  int   rise_cnt = 0, tdi_bad = 0, tms_slip = 0;
  int   hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  logic rec [4096];
  logic tck_prev = 1'b0, tms_prev = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      rise_cnt <= 0; hi_run <= 0; lo_run <= 0;
      tck_prev <= 1'b0;
    end else begin
      if (tck && !tck_prev) begin
        rec[rise_cnt % 4096] <= tms;
        rise_cnt <= rise_cnt + 1;
        if (tdi !== 1'b1) tdi_bad <= tdi_bad + 1;
        last_lo <= lo_run;
        lo_run <= 0;
      end
      if (tck && tck_prev && (tms !== tms_prev)) tms_slip <= tms_slip + 1;
      if (tck) hi_run <= hi_run + 1;
      else begin
        if (hi_run > 0) last_hi <= hi_run;
        hi_run <= 0;
        if (!(tck && !tck_prev)) lo_run <= lo_run + 1;
      end
      tck_prev <= tck;
      tms_prev <= tms;
    end
  end

  task automatic chk(input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, expv);
    end
  endtask

  function automatic int pat_since(input int base, input int n);
    int p = 0;
    for (int i = 0; i < n && i < 16; i++)
      if (rec[(base + i) % 4096]) p |= (1 << i);
    return p;
  endfunction

  task automatic run_req(input logic [4:0] s, input logic [4:0] d,
                         input int ep, input int ec, input int es,
                         input bit exp_err, input string tag);
    int base, guard, got_err, got_done;
    @(negedge clk);
    base = rise_cnt;
    src_code = s; dst_code = d; start = 1'b1;
    guard = 0; got_err = 0; got_done = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      if (done) got_done = 1;
      if (err)  got_err = 1;
      guard++;
    end while (!(got_done || got_err) && guard < 3000);
    chk({tag, " err flag"}, got_err, exp_err ? 1 : 0);
    chk({tag, " done flag"}, got_done, exp_err ? 0 : 1);
    chk({tag, " tck count"}, rise_cnt - base, ec);
    chk({tag, " tms pattern"}, pat_since(base, rise_cnt - base), ep);
    chk({tag, " state"}, int'(cur_state), es);
  endtask

  // {src[29:25], dst[24:20], pattern[19:4], count[3:0]}
  localparam logic [29:0] VECS [13] = '{
    {5'd1,  5'd4,  16'h0001, 4'd3},
    {5'd1,  5'd11, 16'h0003, 4'd4},
    {5'd0,  5'd1,  16'h0000, 4'd1},
    {5'd4,  5'd1,  16'h0003, 4'd3},
    {5'd11, 5'd15, 16'h0003, 4'd2},
    {5'd3,  5'd0,  16'h01FF, 4'd9},
    {5'd3,  5'd6,  16'h0001, 4'd2},
    {5'd6,  5'd11, 16'h000F, 4'd6},
    {5'd15, 5'd6,  16'h0005, 4'd4},
    {5'd2,  5'd1,  16'h0003, 4'd3},
    {5'd10, 5'd2,  16'h0007, 4'd3},
    {5'd12, 5'd11, 16'h0002, 4'd3},
    {5'd14, 5'd11, 16'h0000, 4'd1}
  };

  initial begin
    int base;
    // R1: pin levels under reset
    repeat (3) @(negedge clk);
    chk("R1 tck in reset", int'(tck), 0);
    chk("R1 tdi in reset", int'(tdi), 1);
    chk("R1 tms in reset", int'(tms), 1);
    rst_n = 1'b1;
    // R1: automatic run to state 0
    for (int g = 0; g < 500 && busy; g++) @(negedge clk);
    chk("R1 boot tck count", rise_cnt, 9);
    chk("R1 boot pattern", pat_since(0, rise_cnt), 16'h01FF);
    chk("R1 boot state", int'(cur_state), 0);

    // R2/R3/R4: route table walk
    for (int v = 0; v < 13; v++)
      run_req(VECS[v][29:25], VECS[v][24:20], int'(VECS[v][19:4]),
              int'(VECS[v][3:0]), int'(VECS[v][24:20]), 1'b0,
              $sformatf("R3/R2 vec%0d", v));

    // R5: equal codes, state stays Shift-IR (11)
    run_req(5'd4, 5'd4, 0, 0, 11, 1'b0, "R5 equal codes");
    // R6/R7: current resolves to Shift-IR, no self cycle
    run_req(5'd16, 5'd11, 0, 0, 11, 1'b0, "R7 shift self");
    // R6: current (Shift-IR) to Pause-DR
    run_req(5'd16, 5'd6, 16'h17, 6, 6, 1'b0, "R6 cur source");
    // R7: Pause-DR self gives one TMS-low clock
    run_req(5'd16, 5'd6, 16'h0, 1, 6, 1'b0, "R7 pause self");
    // R6: destination code 16 resolves to Pause-DR
    run_req(5'd4, 5'd16, 16'h01, 2, 6, 1'b0, "R6 cur dest");
    run_req(5'd16, 5'd1, 16'h03, 3, 1, 1'b0, "R6 to idle");
    run_req(5'd16, 5'd1, 16'h0, 1, 1, 1'b0, "R7 idle self");
    // R8: out-of-range codes
    run_req(5'd17, 5'd4, 0, 0, 1, 1'b1, "R8 bad source");
    run_req(5'd2, 5'd31, 0, 0, 1, 1'b1, "R8 bad dest");
    // R4: destination 0 from Run-Test/Idle
    run_req(5'd16, 5'd0, 16'h1FF, 9, 0, 1'b0, "R4 reset path");

    // R10: divider lengths
    lo_clks = 8'd3; hi_clks = 8'd4;
    run_req(5'd1, 5'd11, 16'h3, 4, 11, 1'b0, "R10 slow");
    chk("R10 low phase", last_lo, 3);
    chk("R10 high phase", last_hi, 4);
    lo_clks = 8'd0; hi_clks = 8'd0;
    run_req(5'd1, 5'd4, 16'h1, 3, 4, 1'b0, "R10 zero lengths");
    chk("R10 low phase zero", last_lo, 1);
    chk("R10 high phase zero", last_hi, 1);

    // R11: start during a running sequence is ignored
    lo_clks = 8'd2; hi_clks = 8'd1;
    @(negedge clk);
    base = rise_cnt;
    src_code = 5'd1; dst_code = 5'd11; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    src_code = 5'd0; dst_code = 5'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int g = 0; g < 500 && busy; g++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R11 busy start tck count", rise_cnt - base, 4);
    chk("R11 busy start state", int'(cur_state), 11);
    chk("R11 idle after", int'(busy), 0);

    // R9: pin discipline over the whole run
    chk("R9 tdi high at rise", tdi_bad, 0);
    chk("R9 tms stable while tck high", tms_slip, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule